// File: doc/BRIEF.md
# PCI Function Slot Table and Event Queue

This block keeps a small table of PCI function slots. A populated slot carries a function identifier, a function handle and a configured flag. Configure and deconfigure requests name a function by identifier. Each request gets a response code one cycle later. A deconfigure that takes effect also pulses a release line for that slot, so that neighbouring logic can drop its interrupt registration and its address translation for the function.

Hot-plug and hot-unplug strobes arrive one bit per slot. They are latched and then serviced one slot per cycle, lowest slot first. Each one fills or empties its slot and writes availability records into a pending-event FIFO. An error-injection port writes error records into the same FIFO. A consumer sees a single pending flag. Each pop returns the oldest record, packed big-endian into a fixed-size vector. Two side lookups are combinational: one maps a handle to its slot, and the other returns the N-th populated slot.

Top module: `pcifn_evq`

## Requirements
- R1: After reset every slot is empty (handle 0). `evt_pending_o`, `overflow_o`, `resp_valid_o` and `rec_valid_o` are all 0.
- R2: A plug strobe on slot s sets the identifier to s, the handle to s with bit 31 set, and the configured flag. It queues two availability records in this order: event code 0x0301 (reserved to standby), then 0x0302 (standby to configured).
- R3: A configure request returns its response code the cycle after it is accepted. The code is 0x0003 if no populated slot has that identifier, 0x0002 if the function is already configured, and otherwise 0x0001, which also sets the flag.
- R4: A deconfigure request returns 0x0003 for an unknown identifier and 0x0002 if the function is not configured. Otherwise it returns 0x0001, clears the flag, and raises `release_o` for that slot alone, in the same cycle as the response.
- R5: An unplug of slot s queues 0x0303 (configured to standby) only if the function was configured, and always follows it with 0x0304 (standby to reserved). Both records carry the old identifier and handle. The slot's handle and identifier then become 0.
- R6: Identifier lookup only considers slots whose handle is nonzero.
- R7: Handle lookup never hits for handle 0. Otherwise it reports the slot that holds that handle.
- R8: Index lookup N returns the N-th slot with a nonzero handle, counting from 0 in ascending slot order. It misses when fewer slots are populated.
- R9: An error injection on slot s queues a record with type 1. It carries that slot's current identifier and handle, the 32-bit detail word, the 64-bit fault address and the 16-bit event code.
- R10: A pop returns the oldest record on `rec_o` one cycle later. The layout is, MSB first: length 16 bits (=26), notification type 8 bits (=2), record type 8 bits, identifier 32, handle 32, detail 32, fault address 64, event code 16. Availability records have zero detail and address.
- R11: When the FIFO has no room, new records are dropped and `overflow_o` is set. It stays set until reset. The slot state still updates.
- R12: `evt_pending_o` is high whenever a record is held. A pop while the FIFO is empty is ignored, and `rec_valid_o` stays 0.
- R13: An error injection takes priority over hot-plug service in the same cycle. Strobes on several slots are serviced lowest slot first, and each slot's records are kept together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| plug_i | input | NUM_SLOTS | Hot-plug strobe per slot |
| unplug_i | input | NUM_SLOTS | Hot-unplug strobe per slot |
| req_valid_i | input | 1 | Configuration request strobe |
| req_deconf_i | input | 1 | 1 = deconfigure, 0 = configure |
| req_fid_i | input | 32 | Function identifier of the request |
| resp_valid_o | output | 1 | Response valid |
| resp_code_o | output | 16 | Response code |
| release_o | output | NUM_SLOTS | Release pulse for the deconfigured slot |
| err_valid_i | input | 1 | Error injection strobe |
| err_slot_i | input | SLOT_W | Slot of the failing function |
| err_code_i | input | 16 | Error event code |
| err_addr_i | input | 64 | Fault address |
| err_detail_i | input | 32 | Error detail word |
| lkh_handle_i | input | 32 | Handle to look up |
| lkh_hit_o | output | 1 | Handle lookup hit |
| lkh_slot_o | output | SLOT_W | Slot matching the handle |
| idx_i | input | SLOT_W | Index for populated-slot lookup |
| idx_hit_o | output | 1 | Index lookup hit |
| idx_slot_o | output | SLOT_W | Slot at that index |
| evt_pending_o | output | 1 | At least one record queued |
| pop_i | input | 1 | Pop the oldest record |
| rec_valid_o | output | 1 | Popped record valid |
| rec_o | output | 208 | Popped record, big-endian layout |
| overflow_o | output | 1 | Sticky record-drop flag |

## Verification
Some properties are checked on every cycle:
- each request is answered on the next cycle;
- the release vector is one-hot or zero, and is only raised with a completion code;
- a zero handle never hits;
- the FIFO occupancy stays within bounds;
- the overflow flag stays set once raised;
- a pop on an empty FIFO yields nothing.

The content and order of records need the bench's scenarios to show them. These cover the paired plug events, the conditional unplug event, error records taking precedence over a concurrent plug, lowest-slot-first servicing, and the drop of whole records once the queue is full. The idempotent response codes, and lookups after slots empty, are shown the same way.

// File: rtl/pcifn_pkg.sv
package pcifn_pkg;
  localparam int FID_W = 32;
  localparam int FH_W  = 32;
  localparam int DET_W = 32;
  localparam int ADR_W = 64;
  localparam int PEC_W = 16;
  localparam int REC_BYTES = 26;
  localparam int REC_W = REC_BYTES * 8;
  localparam int VFLAG_BIT = 31;

  localparam logic [15:0] RSP_DONE    = 16'h0001;
  localparam logic [15:0] RSP_NOOP    = 16'h0002;
  localparam logic [15:0] RSP_UNKNOWN = 16'h0003;

  localparam logic [PEC_W-1:0] PEC_RES2STBY = 16'h0301;
  localparam logic [PEC_W-1:0] PEC_STBY2CFG = 16'h0302;
  localparam logic [PEC_W-1:0] PEC_CFG2STBY = 16'h0303;
  localparam logic [PEC_W-1:0] PEC_STBY2RES = 16'h0304;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_ERR   = 2'd1,
    EV_AVAIL = 2'd2
  } ev_kind_e;

  typedef struct packed {
    ev_kind_e          kind;
    logic [FID_W-1:0]  fid;
    logic [FH_W-1:0]   fh;
    logic [DET_W-1:0]  detail;
    logic [ADR_W-1:0]  addr;
    logic [PEC_W-1:0]  pec;
  } ev_t;

  function automatic ev_t mk_avail(logic [PEC_W-1:0] pec, logic [FID_W-1:0] fid,
                                   logic [FH_W-1:0] fh);
    ev_t e;
    e.kind   = EV_AVAIL;
    e.fid    = fid;
    e.fh     = fh;
    e.detail = '0;
    e.addr   = '0;
    e.pec    = pec;
    return e;
  endfunction
endpackage

// File: rtl/pcifn_slot_table.sv
module pcifn_slot_table
  import pcifn_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] plug_i,
  input  logic [NUM_SLOTS-1:0] unplug_i,
  input  logic                 req_valid_i,
  input  logic                 req_deconf_i,
  input  logic [FID_W-1:0]     req_fid_i,
  output logic                 resp_valid_o,
  output logic [15:0]          resp_code_o,
  output logic [NUM_SLOTS-1:0] release_o,
  input  logic                 err_valid_i,
  input  logic [SLOT_W-1:0]    err_slot_i,
  input  logic [PEC_W-1:0]     err_code_i,
  input  logic [ADR_W-1:0]     err_addr_i,
  input  logic [DET_W-1:0]     err_detail_i,
  input  logic [FH_W-1:0]      lkh_handle_i,
  output logic                 lkh_hit_o,
  output logic [SLOT_W-1:0]    lkh_slot_o,
  input  logic [SLOT_W-1:0]    idx_i,
  output logic                 idx_hit_o,
  output logic [SLOT_W-1:0]    idx_slot_o,
  output logic                 push0_v_o,
  output ev_t                  push0_o,
  output logic                 push1_v_o,
  output ev_t                  push1_o
);

  logic [FH_W-1:0]      fh_q  [NUM_SLOTS];
  logic [FID_W-1:0]     fid_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] cfg_q;
  logic [NUM_SLOTS-1:0] plug_pend_q, unplug_pend_q;

  function automatic logic [FH_W-1:0] slot_fh(logic [SLOT_W-1:0] s);
    logic [FH_W-1:0] h;
    h = FH_W'(s);
    h[VFLAG_BIT] = 1'b1;
    return h;
  endfunction

  // identifier lookup, populated slots only, lowest slot wins
  logic              fid_hit;
  logic [SLOT_W-1:0] fid_slot;
  always_comb begin
    fid_hit  = 1'b0;
    fid_slot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (fh_q[i] != '0 && fid_q[i] == req_fid_i) begin
        fid_hit  = 1'b1;
        fid_slot = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    lkh_hit_o  = 1'b0;
    lkh_slot_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (lkh_handle_i != '0 && fh_q[i] == lkh_handle_i) begin
        lkh_hit_o  = 1'b1;
        lkh_slot_o = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    logic [SLOT_W:0] n;
    n          = '0;
    idx_hit_o  = 1'b0;
    idx_slot_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (fh_q[i] != '0) begin
        if (!idx_hit_o && n == {1'b0, idx_i}) begin
          idx_hit_o  = 1'b1;
          idx_slot_o = SLOT_W'(i);
        end
        n = n + 1'b1;
      end
    end
  end

  // hot-plug sequencer: one slot per cycle, lowest first, yields to errors
  logic [NUM_SLOTS-1:0] any_pend;
  logic                 svc_any, svc_plug, do_svc;
  logic [SLOT_W-1:0]    svc_slot;
  assign any_pend = plug_pend_q | unplug_pend_q;
  assign svc_any  = |any_pend;
  assign do_svc   = svc_any && !err_valid_i;

  always_comb begin
    svc_slot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (any_pend[i]) svc_slot = SLOT_W'(i);
    end
  end
  assign svc_plug = plug_pend_q[svc_slot];

  logic [NUM_SLOTS-1:0] clr_plug, clr_unplug;
  always_comb begin
    clr_plug   = '0;
    clr_unplug = '0;
    if (do_svc) begin
      if (svc_plug) clr_plug[svc_slot]   = 1'b1;
      else          clr_unplug[svc_slot] = 1'b1;
    end
  end

  always_comb begin
    push0_v_o = 1'b0;
    push1_v_o = 1'b0;
    push0_o   = '0;
    push1_o   = '0;
    if (err_valid_i) begin
      push0_v_o      = 1'b1;
      push0_o.kind   = EV_ERR;
      push0_o.fid    = fid_q[err_slot_i];
      push0_o.fh     = fh_q[err_slot_i];
      push0_o.detail = err_detail_i;
      push0_o.addr   = err_addr_i;
      push0_o.pec    = err_code_i;
    end else if (do_svc && svc_plug) begin
      push0_v_o = 1'b1;
      push1_v_o = 1'b1;
      push0_o   = mk_avail(PEC_RES2STBY, FID_W'(svc_slot), slot_fh(svc_slot));
      push1_o   = mk_avail(PEC_STBY2CFG, FID_W'(svc_slot), slot_fh(svc_slot));
    end else if (do_svc) begin
      push0_v_o = 1'b1;
      if (cfg_q[svc_slot]) begin
        push1_v_o = 1'b1;
        push0_o   = mk_avail(PEC_CFG2STBY, fid_q[svc_slot], fh_q[svc_slot]);
        push1_o   = mk_avail(PEC_STBY2RES, fid_q[svc_slot], fh_q[svc_slot]);
      end else begin
        push0_o   = mk_avail(PEC_STBY2RES, fid_q[svc_slot], fh_q[svc_slot]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plug_pend_q   <= '0;
      unplug_pend_q <= '0;
    end else begin
      plug_pend_q   <= (plug_pend_q & ~clr_plug) | plug_i;
      unplug_pend_q <= (unplug_pend_q & ~clr_unplug) | unplug_i;
    end
  end

  // request handling first, hot-plug service overrides on the same slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        fh_q[i]  <= '0;
        fid_q[i] <= '0;
      end
      cfg_q        <= '0;
      resp_valid_o <= 1'b0;
      resp_code_o  <= '0;
      release_o    <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      release_o    <= '0;
      if (req_valid_i) begin
        if (!fid_hit) begin
          resp_code_o <= RSP_UNKNOWN;
        end else if (req_deconf_i) begin
          if (cfg_q[fid_slot]) begin
            resp_code_o         <= RSP_DONE;
            cfg_q[fid_slot]     <= 1'b0;
            release_o[fid_slot] <= 1'b1;
          end else begin
            resp_code_o <= RSP_NOOP;
          end
        end else begin
          if (cfg_q[fid_slot]) begin
            resp_code_o <= RSP_NOOP;
          end else begin
            resp_code_o     <= RSP_DONE;
            cfg_q[fid_slot] <= 1'b1;
          end
        end
      end
      if (do_svc && svc_plug) begin
        fh_q[svc_slot]  <= slot_fh(svc_slot);
        fid_q[svc_slot] <= FID_W'(svc_slot);
        cfg_q[svc_slot] <= 1'b1;
      end else if (do_svc) begin
        fh_q[svc_slot]  <= '0;
        fid_q[svc_slot] <= '0;
        cfg_q[svc_slot] <= 1'b0;
      end
    end
  end

  p_resp_follows_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  p_rel_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(release_o));
  p_rel_with_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|release_o) |-> (resp_valid_o && resp_code_o == RSP_DONE));
  p_lkh_zero_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkh_handle_i == '0) |-> !lkh_hit_o);
endmodule

// File: rtl/pcifn_evt_fifo.sv
module pcifn_evt_fifo
  import pcifn_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push0_v_i,
  input  ev_t  push0_i,
  input  logic push1_v_i,
  input  ev_t  push1_i,
  input  logic pop_i,
  output logic pending_o,
  output logic rd_valid_o,
  output ev_t  rd_data_o,
  output logic overflow_o
);

  ev_t              mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic             acc0, acc1, do_pop, drop;
  logic [PTR_W-1:0] wa0, wa1;
  assign acc0   = push0_v_i && (int'(cnt_q) < DEPTH);
  assign acc1   = push1_v_i && (int'(cnt_q) + (acc0 ? 1 : 0) < DEPTH);
  assign drop   = (push0_v_i && !acc0) || (push1_v_i && !acc1);
  assign do_pop = pop_i && (cnt_q != '0);
  assign wa0    = wr_ptr_q;
  assign wa1    = acc0 ? nxt(wr_ptr_q) : wr_ptr_q;
  assign pending_o = (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (acc0) mem_q[wa0] <= push0_i;
    if (acc1) mem_q[wa1] <= push1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      cnt_q      <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (acc1)      wr_ptr_q <= nxt(wa1);
      else if (acc0) wr_ptr_q <= nxt(wa0);
      if (do_pop) begin
        rd_ptr_q  <= nxt(rd_ptr_q);
        rd_data_o <= mem_q[rd_ptr_q];
      end
      rd_valid_o <= do_pop;
      cnt_q      <= cnt_q + CNT_W'(acc0) + CNT_W'(acc1) - CNT_W'(do_pop);
      if (drop) overflow_o <= 1'b1;
    end
  end

  p_count_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= DEPTH);
  p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  p_pop_empty_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !pending_o) |=> !rd_valid_o);
  p_pending_after_push_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push0_v_i && !pop_i) |=> pending_o);
endmodule

// File: rtl/pcifn_rec_fmt.sv
module pcifn_rec_fmt
  import pcifn_pkg::*;
(
  input  ev_t              ev_i,
  output logic [REC_W-1:0] rec_o
);
  logic [7:0]       cc;
  logic [DET_W-1:0] det;
  logic [ADR_W-1:0] adr;

  assign cc  = {6'd0, ev_i.kind};
  assign det = (ev_i.kind == EV_ERR) ? ev_i.detail : '0;
  assign adr = (ev_i.kind == EV_ERR) ? ev_i.addr : '0;
  // MSB-first packing gives network byte order on the wire
  assign rec_o = {16'(REC_BYTES), 8'd2, cc, ev_i.fid, ev_i.fh, det, adr, ev_i.pec};
endmodule

// File: rtl/pcifn_evq.sv
module pcifn_evq
  import pcifn_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int DEPTH = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] plug_i,
  input  logic [NUM_SLOTS-1:0] unplug_i,
  input  logic                 req_valid_i,
  input  logic                 req_deconf_i,
  input  logic [31:0]          req_fid_i,
  output logic                 resp_valid_o,
  output logic [15:0]          resp_code_o,
  output logic [NUM_SLOTS-1:0] release_o,
  input  logic                 err_valid_i,
  input  logic [SLOT_W-1:0]    err_slot_i,
  input  logic [15:0]          err_code_i,
  input  logic [63:0]          err_addr_i,
  input  logic [31:0]          err_detail_i,
  input  logic [31:0]          lkh_handle_i,
  output logic                 lkh_hit_o,
  output logic [SLOT_W-1:0]    lkh_slot_o,
  input  logic [SLOT_W-1:0]    idx_i,
  output logic                 idx_hit_o,
  output logic [SLOT_W-1:0]    idx_slot_o,
  output logic                 evt_pending_o,
  input  logic                 pop_i,
  output logic                 rec_valid_o,
  output logic [207:0]         rec_o,
  output logic                 overflow_o
);
  logic push0_v, push1_v;
  ev_t  push0, push1, rd_data;

  pcifn_slot_table #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk_i, .rst_ni, .plug_i, .unplug_i,
    .req_valid_i, .req_deconf_i, .req_fid_i,
    .resp_valid_o, .resp_code_o, .release_o,
    .err_valid_i, .err_slot_i, .err_code_i, .err_addr_i, .err_detail_i,
    .lkh_handle_i, .lkh_hit_o, .lkh_slot_o,
    .idx_i, .idx_hit_o, .idx_slot_o,
    .push0_v_o(push0_v), .push0_o(push0), .push1_v_o(push1_v), .push1_o(push1)
  );

  pcifn_evt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push0_v_i(push0_v), .push0_i(push0), .push1_v_i(push1_v), .push1_i(push1),
    .pop_i, .pending_o(evt_pending_o), .rd_valid_o(rec_valid_o),
    .rd_data_o(rd_data), .overflow_o
  );

  pcifn_rec_fmt u_fmt (.ev_i(rd_data), .rec_o);
endmodule

// File: tb/pcifn_evq_tb.sv
`timescale 1ns/1ps
module pcifn_evq_tb;
  localparam int N = 8;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] plug_i = '0, unplug_i = '0, release_o;
  logic         req_valid_i = 0, req_deconf_i = 0, resp_valid_o;
  logic [31:0]  req_fid_i = '0, err_detail_i = '0, lkh_handle_i = '0;
  logic [15:0]  resp_code_o, err_code_i = '0;
  logic         err_valid_i = 0, lkh_hit_o, idx_hit_o, evt_pending_o, rec_valid_o, overflow_o;
  logic [2:0]   err_slot_i = '0, lkh_slot_o, idx_i = '0, idx_slot_o;
  logic [63:0]  err_addr_i = '0;
  logic [207:0] rec_o;
  logic         mon_pop = 0, tb_pop = 0, pop_i;
  assign pop_i = mon_pop | tb_pop;

  pcifn_evq #(.NUM_SLOTS(N), .DEPTH(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .plug_i, .unplug_i,
    .req_valid_i, .req_deconf_i, .req_fid_i, .resp_valid_o, .resp_code_o, .release_o,
    .err_valid_i, .err_slot_i, .err_code_i, .err_addr_i, .err_detail_i,
    .lkh_handle_i, .lkh_hit_o, .lkh_slot_o, .idx_i, .idx_hit_o, .idx_slot_o,
    .evt_pending_o, .pop_i, .rec_valid_o, .rec_o, .overflow_o
  );

  int checks = 0, fails = 0;
  bit mon_en = 0, done = 0;
  logic [207:0] exp_q[$];

  task automatic chk(bit ok, string req, string what, logic [207:0] act, logic [207:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [207:0] rec(logic [7:0] cc, logic [31:0] fid, logic [31:0] fh,
                                       logic [31:0] det, logic [63:0] adr, logic [15:0] pec);
    return {16'd26, 8'd2, cc, fid, fh, det, adr, pec};
  endfunction
  function automatic logic [31:0] hdl(int s);
    return 32'h8000_0000 | 32'(s);
  endfunction

  // monitor: pops whenever enabled and compares against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && evt_pending_o) begin
        mon_pop = 1;
        @(negedge clk);
        mon_pop = 0;
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected record", rec_o, '0);
        end else begin
          logic [207:0] e;
          e = exp_q.pop_front();
          chk(rec_valid_o === 1'b1 && rec_o === e, "R10", "record", rec_o, e);
        end
      end
    end
  end

  task automatic drain(string req);
    int n = 0;
    mon_en = 1;
    while ((exp_q.size() != 0 || evt_pending_o) && n < 400) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && !evt_pending_o, req, "drain", 208'(exp_q.size()), '0);
  endtask

  task automatic plug(logic [N-1:0] m);
    @(negedge clk); plug_i = m;
    @(negedge clk); plug_i = '0;
    for (int s = 0; s < N; s++) if (m[s]) begin
      exp_q.push_back(rec(8'd2, 32'(s), hdl(s), '0, '0, 16'h0301));
      exp_q.push_back(rec(8'd2, 32'(s), hdl(s), '0, '0, 16'h0302));
    end
  endtask

  task automatic unplug(int s, bit was_cfg);
    @(negedge clk); unplug_i[s] = 1;
    @(negedge clk); unplug_i = '0;
    if (was_cfg) exp_q.push_back(rec(8'd2, 32'(s), hdl(s), '0, '0, 16'h0303));
    exp_q.push_back(rec(8'd2, 32'(s), hdl(s), '0, '0, 16'h0304));
  endtask

  task automatic req(bit dec, int fid, logic [15:0] code, logic [N-1:0] rel, string r);
    @(negedge clk); req_valid_i = 1; req_deconf_i = dec; req_fid_i = 32'(fid);
    @(negedge clk); req_valid_i = 0;
    chk(resp_valid_o && resp_code_o == code, r, "response code", 208'(resp_code_o), 208'(code));
    chk(release_o == rel, "R4", "release", 208'(release_o), 208'(rel));
  endtask

  task automatic lkh(logic [31:0] h, bit hit, int slot, string r);
    @(negedge clk); lkh_handle_i = h; #1;
    chk(lkh_hit_o == hit && (!hit || lkh_slot_o == 3'(slot)), r, "handle lookup",
        208'({lkh_hit_o, lkh_slot_o}), 208'({hit, 3'(slot)}));
  endtask

  task automatic idx(int i, bit hit, int slot);
    @(negedge clk); idx_i = 3'(i); #1;
    chk(idx_hit_o == hit && (!hit || idx_slot_o == 3'(slot)), "R8", "index lookup",
        208'({idx_hit_o, idx_slot_o}), 208'({hit, 3'(slot)}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!evt_pending_o && !overflow_o && !resp_valid_o && !rec_valid_o, "R1", "reset flags",
        208'({evt_pending_o, overflow_o, resp_valid_o, rec_valid_o}), '0);
    rst_n = 1;
    lkh(hdl(0), 0, 0, "R1");
    idx(0, 0, 0);
    // R2 plug slot 3
    plug(8'b0000_1000);
    drain("R2");
    lkh(hdl(3), 1, 3, "R2");
    // R3 / R4 idempotent codes
    req(0, 3, 16'h0002, '0, "R3");
    req(1, 3, 16'h0001, 8'b0000_1000, "R4");
    req(1, 3, 16'h0002, '0, "R4");
    req(0, 3, 16'h0001, '0, "R3");
    req(0, 5, 16'h0003, '0, "R3");
    req(0, 0, 16'h0003, '0, "R6");
    // R13 simultaneous plugs, lowest first; R8 index lookup
    plug(8'b0100_0010);
    drain("R13");
    idx(0, 1, 1); idx(1, 1, 3); idx(2, 1, 6); idx(3, 0, 0);
    // R5 unplug of a deconfigured then a configured function
    req(1, 6, 16'h0001, 8'b0100_0000, "R4");
    unplug(6, 0);
    unplug(1, 1);
    drain("R5");
    lkh(hdl(6), 0, 0, "R5");
    lkh(32'h0, 0, 0, "R7");
    req(0, 6, 16'h0003, '0, "R6");
    idx(1, 0, 0);
    // R9 error record, R13 priority over a concurrent plug
    @(negedge clk);
    err_valid_i = 1; err_slot_i = 3; err_code_i = 16'h0042;
    err_addr_i = 64'h0123_4567_89AB_CDEF; err_detail_i = 32'h8000_0000;
    plug_i = 8'b0000_0100;
    @(negedge clk); err_valid_i = 0; plug_i = '0;
    exp_q.push_back(rec(8'd1, 32'd3, hdl(3), 32'h8000_0000, 64'h0123_4567_89AB_CDEF, 16'h0042));
    for (int k = 0; k < 2; k++)
      exp_q.push_back(rec(8'd2, 32'd2, hdl(2), '0, '0, k == 0 ? 16'h0301 : 16'h0302));
    drain("R9");
    // R12 pop on empty
    mon_en = 0;
    @(negedge clk); tb_pop = 1;
    @(negedge clk); tb_pop = 0;
    chk(!rec_valid_o && !evt_pending_o, "R12", "empty pop", 208'({rec_valid_o, evt_pending_o}), '0);
    // R11 overflow: 8 records fill the queue, next plug is dropped
    plug(8'b0001_0000); plug(8'b0010_0000); plug(8'b1000_0000);
    unplug(2, 1);
    @(negedge clk); plug_i = 8'b0000_0001;
    @(negedge clk); plug_i = '0;
    repeat (3) @(negedge clk);
    chk(overflow_o && evt_pending_o, "R11", "overflow set", 208'({overflow_o, evt_pending_o}), 208'(2'b11));
    lkh(hdl(0), 1, 0, "R11");
    drain("R11");
    chk(overflow_o, "R11", "overflow sticky", 208'(overflow_o), 208'(1));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule